// File: doc/BRIEF.md
# Horizontal CCD Pixel Phase Generator

This block produces the logic-level drive waveforms for a two-phase horizontal charge-transfer register and its output stage. It derives them from a system clock that runs at a fixed integer multiple of the pixel rate. Each pixel period is split into a set number of ticks. The first half drives the first horizontal phase and its separately pinned last gate. The second half drives the second phase. A short reset-gate pulse opens each period. The charge packet reaches the sense node on the falling edge of the first phase, so one pixel is delivered per phase cycle.

For a correlated double sampling front end, the block marks two windows. One is a reset-level window after the reset gate has dropped. The other is a signal-level window after the first phase has fallen. A pixel count pulse marks the end of each shifted pixel.

An upstream line sequencer starts and stops shifting with a run enable. Both changes take effect only at a pixel boundary, so no phase is ever cut short. While stopped, the horizontal phases park at a level the sequencer selects. The sequencer normally picks the first phase high during vertical line transfer. The reset gate keeps pulsing throughout.

Top module: `hclk_phase_gen`

## Requirements
- R1: While `rst_n` is low, `h1` and `h1l` are 1 and `h2`, `rg`, `smp_reset`, `smp_signal` and `pixel_tick` are 0.
- R2: While shifting, each pixel period is 8 clock cycles numbered tick 0 to 7. `h1` and `h1l` are high on ticks 0–3 and low on ticks 4–7.
- R3: `rg` is high for exactly one cycle, on tick 0, in every 8-cycle period. This holds whether the block is shifting or parked.
- R4: While shifting, `smp_reset` is high only on tick 2 and `smp_signal` is high only on tick 6. While parked, both stay 0.
- R5: While shifting, `pixel_tick` is high only on tick 7, once per period. While parked, it stays 0.
- R6: `run_en` is sampled only on tick 7. A period that starts parked stays parked to its end, and a pulse of `run_en` that is over before tick 7 causes no shifting.
- R7: Dropping `run_en` mid-period lets the current period finish with its full waveform. Parking begins on the following tick 0.
- R8: While parked, `h1` and `h1l` equal `park_h1_high` and `h2` is its inverse. The outputs follow a change of the input one clock later. While shifting, `park_h1_high` has no effect.
- R9: `h2` is the inverse of `h1` in every cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 8x pixel rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Request horizontal shifting |
| park_h1_high | input | 1 | Parked level of h1/h1l (h2 takes the inverse) |
| h1 | output | 1 | Horizontal phase 1 |
| h2 | output | 1 | Horizontal phase 2 |
| h1l | output | 1 | Last-gate phase 1, separately timed |
| rg | output | 1 | Reset gate pulse |
| smp_reset | output | 1 | Reset-level sample window |
| smp_signal | output | 1 | Signal-level sample window |
| pixel_tick | output | 1 | One pulse per completed shifted pixel |

## Verification
Every output is registered. A change on `park_h1_high` appears one clock later. A change on `run_en` takes effect on the tick 0 that follows the next tick 7, which can be up to eight cycles later. The bench samples on the falling clock edge. It locks its own tick count to the first `rg` pulse after reset and advances that count by one per cycle. Each expected waveform is therefore compared at the exact tick position where the requirements place it. Stimulus is applied just after a comparison, so its first visible effect falls on the next sample.

// File: rtl/hclk_pkg.sv
package hclk_pkg;

  // Bundle of all registered drive outputs
  typedef struct packed {
    logic h1;
    logic h1l;
    logic h2;
    logic rg;
    logic smp_reset;
    logic smp_signal;
    logic pixel_tick;
  } hclk_drive_t;

  localparam hclk_drive_t HCLK_DRIVE_RESET = '{
    h1: 1'b1, h1l: 1'b1, h2: 1'b0, rg: 1'b0,
    smp_reset: 1'b0, smp_signal: 1'b0, pixel_tick: 1'b0
  };

endpackage

// File: rtl/hclk_tick_counter.sv
module hclk_tick_counter #(
  parameter int TICKS = 8,
  localparam int CNT_W = $clog2(TICKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt_next_o,
  output logic             last_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    last_o = (cnt_q == CNT_W'(TICKS - 1));
    if (last_o) cnt_d = '0;
    else        cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_next_o = cnt_d;

endmodule

// File: rtl/hclk_run_ctrl.sv
module hclk_run_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic last_i,
  input  logic run_en_i,
  output logic shift_next_o
);

  logic shift_q;
  logic shift_d;

  // Run request is only honoured at a pixel boundary
  always_comb begin
    shift_d = shift_q;
    if (last_i) shift_d = run_en_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= 1'b0;
    else        shift_q <= shift_d;
  end

  assign shift_next_o = shift_d;

endmodule

// File: rtl/hclk_phase_decode.sv
module hclk_phase_decode
  import hclk_pkg::*;
#(
  parameter int TICKS      = 8,
  parameter int RG_ON      = 0,
  parameter int RG_WIDTH   = 1,
  parameter int H1L_ON     = 0,
  parameter int H1L_OFF    = TICKS / 2,
  parameter int RST_TICK   = 2,
  parameter int SIG_TICK   = 6,
  localparam int CNT_W     = $clog2(TICKS),
  localparam int HALF      = TICKS / 2,
  localparam int RG_OFF    = RG_ON + RG_WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             shift_i,
  input  logic             park_hi_i,
  output hclk_drive_t      drive_o
);

  hclk_drive_t drv_d;
  hclk_drive_t drv_q;
  logic        h1_win;
  logic        h1l_win;
  logic        rg_win;

  assign h1_win = (cnt_i < CNT_W'(HALF));
  assign rg_win = (cnt_i >= CNT_W'(RG_ON)) && (cnt_i < CNT_W'(RG_OFF));

  // Last-gate window: reuse h1 when untrimmed, else decode its own window
  generate
    if (H1L_ON == 0 && H1L_OFF == HALF) begin : g_h1l_same
      assign h1l_win = h1_win;
    end else begin : g_h1l_trim
      assign h1l_win = (cnt_i >= CNT_W'(H1L_ON)) && (cnt_i < CNT_W'(H1L_OFF));
    end
  endgenerate

  always_comb begin
    drv_d    = '0;
    drv_d.rg = rg_win;
    if (shift_i) begin
      drv_d.h1         = h1_win;
      drv_d.h1l        = h1l_win;
      drv_d.h2         = ~h1_win;
      drv_d.smp_reset  = (cnt_i == CNT_W'(RST_TICK));
      drv_d.smp_signal = (cnt_i == CNT_W'(SIG_TICK));
      drv_d.pixel_tick = (cnt_i == CNT_W'(TICKS - 1));
    end else begin
      drv_d.h1  = park_hi_i;
      drv_d.h1l = park_hi_i;
      drv_d.h2  = ~park_hi_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drv_q <= HCLK_DRIVE_RESET;
    else        drv_q <= drv_d;
  end

  assign drive_o = drv_q;

endmodule

// File: rtl/hclk_phase_gen.sv
module hclk_phase_gen
  import hclk_pkg::*;
#(
  parameter int TICKS    = 8,
  parameter int RG_ON    = 0,
  parameter int RG_WIDTH = 1,
  parameter int H1L_ON   = 0,
  parameter int H1L_OFF  = TICKS / 2,
  parameter int RST_TICK = 2,
  parameter int SIG_TICK = 6,
  localparam int CNT_W   = $clog2(TICKS)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  input  logic park_h1_high,
  output logic h1,
  output logic h2,
  output logic h1l,
  output logic rg,
  output logic smp_reset,
  output logic smp_signal,
  output logic pixel_tick
);

  logic [CNT_W-1:0] cnt_next;
  logic             last_tick;
  logic             shift_next;
  hclk_drive_t      drive;

  hclk_tick_counter #(.TICKS(TICKS)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_next_o (cnt_next),
    .last_o     (last_tick)
  );

  hclk_run_ctrl u_run (
    .clk          (clk),
    .rst_n        (rst_n),
    .last_i       (last_tick),
    .run_en_i     (run_en),
    .shift_next_o (shift_next)
  );

  hclk_phase_decode #(
    .TICKS    (TICKS),
    .RG_ON    (RG_ON),
    .RG_WIDTH (RG_WIDTH),
    .H1L_ON   (H1L_ON),
    .H1L_OFF  (H1L_OFF),
    .RST_TICK (RST_TICK),
    .SIG_TICK (SIG_TICK)
  ) u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_i     (cnt_next),
    .shift_i   (shift_next),
    .park_hi_i (park_h1_high),
    .drive_o   (drive)
  );

  assign h1         = drive.h1;
  assign h2         = drive.h2;
  assign h1l        = drive.h1l;
  assign rg         = drive.rg;
  assign smp_reset  = drive.smp_reset;
  assign smp_signal = drive.smp_signal;
  assign pixel_tick = drive.pixel_tick;

endmodule

// File: rtl/hclk_phase_gen_chk.sv
module hclk_phase_gen_chk #(
  parameter int TICKS = 8,
  localparam int GAP_W = $clog2(TICKS) + 2
) (
  input logic clk,
  input logic rst_n,
  input logic h1,
  input logic h2,
  input logic rg,
  input logic smp_reset,
  input logic smp_signal,
  input logic pixel_tick
);

  logic             rg_q;
  logic             seen_q;
  logic [GAP_W-1:0] gap_q;
  logic             rg_rise;

  assign rg_rise = rg && !rg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rg_q   <= 1'b0;
      seen_q <= 1'b0;
      gap_q  <= '0;
    end else begin
      rg_q <= rg;
      if (rg_rise) begin
        seen_q <= 1'b1;
        gap_q  <= GAP_W'(1);
      end else if (gap_q != '1) begin
        gap_q <= gap_q + GAP_W'(1);
      end
    end
  end

  // R9: phases are complementary
  assert_complement_R9: assert property (@(posedge clk) disable iff (!rst_n)
    h2 == !h1);

  // R3: reset gate pulses exactly once per period
  assert_rg_period_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rg_rise && seen_q) |-> (gap_q == GAP_W'(TICKS)));

  // R4: sample windows never coincide with each other or the reset gate
  assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rg, smp_reset, smp_signal}));

  // R4: reset sample sits inside the h1-high half
  assert_rst_in_h1_R4: assert property (@(posedge clk) disable iff (!rst_n)
    smp_reset |-> h1);

  // R2: signal sample comes two cycles after the h1 falling edge
  assert_sig_after_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    smp_signal |-> (!$past(h1, 1) && !$past(h1, 2) && $past(h1, 3)));

  // R5: pixel count pulse closes a period
  assert_pix_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pixel_tick |=> rg);

endmodule

bind hclk_phase_gen hclk_phase_gen_chk #(.TICKS(TICKS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .h1         (h1),
  .h2         (h2),
  .rg         (rg),
  .smp_reset  (smp_reset),
  .smp_signal (smp_signal),
  .pixel_tick (pixel_tick)
);

// File: tb/hclk_phase_gen_test.sv
module hclk_phase_gen_test;

  logic clk = 1'b0;
  logic rst_n;
  logic run_en;
  logic park_h1_high;
  logic h1, h2, h1l, rg, smp_reset, smp_signal, pixel_tick;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  always #2 clk = ~clk;

  hclk_phase_gen uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .run_en       (run_en),
    .park_h1_high (park_h1_high),
    .h1           (h1),
    .h2           (h2),
    .h1l          (h1l),
    .rg           (rg),
    .smp_reset    (smp_reset),
    .smp_signal   (smp_signal),
    .pixel_tick   (pixel_tick)
  );

  // {h1,h1l,h2,rg,smp_reset,smp_signal,pixel_tick}
  function automatic logic [6:0] expect_vec(int t, bit shifting, bit p);
    logic a;
    if (shifting) begin
      a = (t < 4);
      return {a, a, !a, t == 0, t == 2, t == 6, t == 7};
    end
    return {p, p, !p, t == 0, 1'b0, 1'b0, 1'b0};
  endfunction

  task automatic chk(input string req, input logic [6:0] exp);
    logic [6:0] act;
    act = {h1, h1l, h2, rg, smp_reset, smp_signal, pixel_tick};
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: outputs=%b expected=%b", req, act, exp);
    end
  endtask

  // Advance to a falling edge where rg is high (tick 0)
  task automatic sync_tick0();
    bit found = 0;
    for (int i = 0; i < 20 && !found; i++) begin
      @(negedge clk);
      if (rg) found = 1;
    end
    if (!found) begin
      vectors++; fails++;
      $display("FAIL R3: rg=0 for 20 cycles expected=1");
    end
  endtask

  // R1
  task automatic t_reset();
    @(negedge clk);
    chk("R1", 7'b1_1_0_0_0_0_0);
  endtask

  // R3 parked rg keeps pulsing, R8 parked high
  task automatic t_parked();
    sync_tick0();
    for (int p = 0; p < 2; p++)
      for (int t = 0; t < 8; t++) begin
        chk("R3", expect_vec(t, 0, 1));
        @(negedge clk);
      end
  endtask

  // R6 start only at boundary; R2 R4 R5 shifting waveform
  task automatic t_run();
    sync_tick0();
    run_en = 1'b1;
    for (int t = 0; t < 8; t++) begin
      chk("R6", expect_vec(t, 0, 1));
      @(negedge clk);
    end
    for (int p = 0; p < 3; p++)
      for (int t = 0; t < 8; t++) begin
        chk("R2", expect_vec(t, 1, 1));
        @(negedge clk);
      end
  endtask

  // R7 stop mid-period, R8 park level low ignored while shifting
  task automatic t_stop();
    park_h1_high = 1'b0;
    for (int t = 0; t < 8; t++) begin
      chk("R7", expect_vec(t, 1, 0));
      if (t == 2) run_en = 1'b0;
      @(negedge clk);
    end
    for (int t = 0; t < 8; t++) begin
      chk("R8", expect_vec(t, 0, 0));
      @(negedge clk);
    end
  endtask

  // R8 park level follows input one cycle later
  task automatic t_park_level();
    for (int t = 0; t < 8; t++) begin
      chk("R8", expect_vec(t, 0, t >= 4));
      if (t == 3) park_h1_high = 1'b1;
      @(negedge clk);
    end
  endtask

  // R6 pulse that ends before tick 7 starts nothing
  task automatic t_short_pulse();
    for (int p = 0; p < 2; p++)
      for (int t = 0; t < 8; t++) begin
        chk("R6", expect_vec(t, 0, 1));
        if (p == 0 && t == 3) run_en = 1'b1;
        if (p == 0 && t == 5) run_en = 1'b0;
        @(negedge clk);
      end
  endtask

  initial begin
    rst_n = 1'b0;
    run_en = 1'b0;
    park_h1_high = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_parked();
    t_run();
    t_stop();
    t_park_level();
    t_short_pulse();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run incomplete expected=complete");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule